// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block takes the serial receive line of a LIN slave node and recovers the frame header. It needs a strobe at sixteen times the bit rate. While it is idle it ignores all line activity. It starts a header only after the line has stayed low for at least eleven bit times.

After that long low period the block waits for the line to go high again. It then receives one character, which must equal 0x55. If that character is correct, the next character is the frame identifier. The identifier is stored in a register and a sticky flag is set. The two identifier parity bits can also be checked.

A wrong synch character raises a sticky error and sends the block back to idle. Software or a higher-level controller reads the four sticky flags and the stored identifier. It clears the flags with a one-cycle strobe.

Top module: `lin_hdr_rx`

## Requirements
- R1: After reset, all four flags are low and the identifier output is 0x00.
- R2: A low level on the line held for 176 consecutive oversample ticks (11 bit times) sets the break flag. A low run of 10 bit times does not set it.
- R3: After a break, character reception starts only once the line has returned high (the delimiter). The start bit of the synch character is hunted from then on.
- R4: Characters that arrive without a preceding break change no flag and do not change the identifier output.
- R5: The first character after a break must be 0x55. Any other value sets the synch error flag and returns the block to idle. The identifier output then keeps its previous value, and the identifier flag stays low.
- R6: The character that follows a valid synch is loaded into the identifier output, and the identifier flag is set.
- R7: A one-cycle clear strobe resets all four flags. A flag that is set in the same cycle stays set. The identifier output is not affected.
- R8: While parity checking is enabled, the block computes P0 = id[0]^id[1]^id[2]^id[4] and P1 = ~(id[1]^id[3]^id[4]^id[5]). If id[6] differs from P0 or id[7] differs from P1, the parity error flag is set. While checking is disabled, that flag is never set.
- R9: Characters are framed as one low start bit, eight data bits sent LSB first, and a high stop bit. Each bit is decided by a majority vote over oversample ticks 7, 8 and 9. A single wrong tick therefore does not change the result. A start bit that is not low by majority at mid-bit is dropped as a glitch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Serial receive line (idle high, break low) |
| parity_chk_en | input | 1 | Enables the identifier parity check |
| clr_status | input | 1 | One-cycle strobe that clears the sticky flags |
| brk_flag | output | 1 | Sticky: a break was detected |
| id_flag | output | 1 | Sticky: an identifier was received |
| synch_err | output | 1 | Sticky: the synch character was not 0x55 |
| parity_err | output | 1 | Sticky: the identifier parity did not match |
| id_value | output | 8 | Last identifier received |

## Verification
Two things are hard to reach from the ports: the exact break-length boundary and the tolerance at mid-bit. A long low period normally just looks like a zero character to any receiver.

The stimulus drives the line one oversample tick at a time. This lets it place low runs of exactly 10 and 11 bit times. It also lets it insert a short start-bit glitch while the block hunts for the synch character. Finally, it flips one of ticks 7, 8 or 9 inside random header characters, so the majority vote has to decide the result.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    localparam int CHAR_BITS = 8;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_DELIM = 2'd1,
        HS_SYNC  = 2'd2,
        HS_IDENT = 2'd3
    } hdr_state_e;

    typedef enum logic [1:0] {
        CR_IDLE  = 2'd0,
        CR_START = 2'd1,
        CR_DATA  = 2'd2,
        CR_STOP  = 2'd3
    } chr_state_e;

    typedef struct packed {
        logic brk;
        logic ident;
        logic sync_err;
        logic par_err;
    } hdr_flags_t;

    typedef struct packed {
        logic                 done;
        logic [CHAR_BITS-1:0] data;
    } chr_out_t;

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic id_parity_ok(input logic [CHAR_BITS-1:0] id);
        logic p0;
        logic p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return (id[6] == p0) && (id[7] == p1);
    endfunction

endpackage

// File: rtl/lin_in_sync.sv
module lin_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe <= 1'b1;
                else     pipe <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) pipe <= '1;
                else     pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
    parameter int OVS      = 16,
    parameter int BRK_BITS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx,
    output logic hit
);
    localparam int LIM = BRK_BITS * OVS;
    localparam int CW  = $clog2(LIM + 1);
    localparam logic [CW-1:0] LIM_V  = CW'(LIM);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIM - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            hit     <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (tick) begin
                if (rx) begin
                    low_cnt <= '0;
                end else if (low_cnt == LIM_M1) begin
                    low_cnt <= LIM_V;
                    hit     <= 1'b1;
                end else if (low_cnt < LIM_V) begin
                    low_cnt <= low_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lin_char_rx.sv
module lin_char_rx
    import lin_hdr_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     tick,
    input  logic     rx,
    output chr_out_t chr
);
    localparam int TW  = $clog2(OVS);
    localparam int BW  = $clog2(CHAR_BITS);
    localparam logic [TW-1:0] MID   = TW'(OVS / 2);
    localparam logic [TW-1:0] V_LO  = TW'(OVS / 2 - 1);
    localparam logic [TW-1:0] V_HI  = TW'(OVS / 2 + 1);
    localparam logic [TW-1:0] LAST  = TW'(OVS - 1);
    localparam logic [BW-1:0] BLAST = BW'(CHAR_BITS - 1);

    chr_state_e           st;
    logic [TW-1:0]        tcnt;
    logic [BW-1:0]        bidx;
    logic                 vote_a;
    logic                 vote_b;
    logic [CHAR_BITS-1:0] shreg;
    logic                 bit_val;

    assign bit_val = majority3(vote_a, vote_b, rx);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st       <= CR_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            vote_a   <= 1'b1;
            vote_b   <= 1'b1;
            shreg    <= '0;
            chr.done <= 1'b0;
            if (rst) chr.data <= '0;
        end else begin
            chr.done <= 1'b0;
            if (tick) begin
                if (st == CR_IDLE) begin
                    if (!rx) begin
                        st   <= CR_START;
                        tcnt <= TW'(1);
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == V_LO) vote_a <= rx;
                    if (tcnt == MID)  vote_b <= rx;
                    case (st)
                        CR_START: begin
                            if (tcnt == V_HI && bit_val) st <= CR_IDLE;
                            else if (tcnt == LAST) begin
                                st   <= CR_DATA;
                                bidx <= '0;
                            end
                        end
                        CR_DATA: begin
                            if (tcnt == V_HI) shreg <= {bit_val, shreg[CHAR_BITS-1:1]};
                            if (tcnt == LAST) begin
                                if (bidx == BLAST) st <= CR_STOP;
                                else               bidx <= bidx + 1'b1;
                            end
                        end
                        CR_STOP: begin
                            if (tcnt == V_HI) begin
                                chr.done <= 1'b1;
                                chr.data <= shreg;
                                st       <= CR_IDLE;
                            end
                        end
                        default: st <= CR_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/lin_hdr_ctrl.sv
module lin_hdr_ctrl
    import lin_hdr_pkg::*;
#(
    parameter logic [CHAR_BITS-1:0] SYNC_VAL = 8'h55
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rx,
    input  logic                 brk_hit,
    input  chr_out_t             chr,
    input  logic                 par_en,
    input  logic                 clr,
    output hdr_state_e           state,
    output logic                 rx_en,
    output hdr_flags_t           flags,
    output logic [CHAR_BITS-1:0] id_q
);
    hdr_flags_t flg_set;
    hdr_state_e state_n;

    always_comb begin
        flg_set = '0;
        state_n = state;
        case (state)
            HS_DELIM: if (tick && rx) state_n = HS_SYNC;
            HS_SYNC: begin
                if (chr.done) begin
                    if (chr.data == SYNC_VAL) state_n = HS_IDENT;
                    else begin
                        flg_set.sync_err = 1'b1;
                        state_n          = HS_IDLE;
                    end
                end
            end
            HS_IDENT: begin
                if (chr.done) begin
                    flg_set.ident   = 1'b1;
                    flg_set.par_err = par_en && !id_parity_ok(chr.data);
                    state_n         = HS_IDLE;
                end
            end
            default: state_n = state;
        endcase
        if (brk_hit) begin
            flg_set.brk = 1'b1;
            state_n     = HS_DELIM;
        end
    end

    assign rx_en = (state == HS_SYNC) || (state == HS_IDENT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            flags <= '0;
            id_q  <= '0;
        end else begin
            state <= state_n;
            flags <= hdr_flags_t'((clr ? '0 : flags) | flg_set);
            if (state == HS_IDENT && chr.done && !brk_hit) id_q <= chr.data;
        end
    end
endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
    import lin_hdr_pkg::*;
#(
    parameter int                   OVS         = 16,
    parameter int                   BRK_BITS    = 11,
    parameter int                   SYNC_STAGES = 2,
    parameter logic [CHAR_BITS-1:0] SYNC_VAL    = 8'h55
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 parity_chk_en,
    input  logic                 clr_status,
    output logic                 brk_flag,
    output logic                 id_flag,
    output logic                 synch_err,
    output logic                 parity_err,
    output logic [CHAR_BITS-1:0] id_value
);
    logic       rx_s;
    logic       brk_hit;
    logic       rx_en;
    chr_out_t   chr;
    hdr_state_e hdr_state;
    hdr_flags_t flags;

    lin_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d(rxd), .q(rx_s)
    );

    lin_brk_det #(.OVS(OVS), .BRK_BITS(BRK_BITS)) brk_i (
        .clk(clk), .rst(rst), .tick(os_tick), .rx(rx_s), .hit(brk_hit)
    );

    lin_char_rx #(.OVS(OVS)) chr_i (
        .clk(clk), .rst(rst), .en(rx_en), .tick(os_tick), .rx(rx_s), .chr(chr)
    );

    lin_hdr_ctrl #(.SYNC_VAL(SYNC_VAL)) ctrl_i (
        .clk(clk), .rst(rst), .tick(os_tick), .rx(rx_s), .brk_hit(brk_hit),
        .chr(chr), .par_en(parity_chk_en), .clr(clr_status),
        .state(hdr_state), .rx_en(rx_en), .flags(flags), .id_q(id_value)
    );

    assign brk_flag   = flags.brk;
    assign id_flag    = flags.ident;
    assign synch_err  = flags.sync_err;
    assign parity_err = flags.par_err;
endmodule

// File: rtl/lin_hdr_rx_chk.sv
module lin_hdr_rx_chk
    import lin_hdr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       clr_status,
    input logic       parity_chk_en,
    input logic       brk_flag,
    input logic       id_flag,
    input logic       synch_err,
    input logic       parity_err,
    input logic [7:0] id_value,
    input hdr_state_e hdr_state,
    input logic       brk_hit
);
    assert_brk_enters_delim_R3: assert property (@(posedge clk) disable iff (rst)
        brk_hit |=> hdr_state == HS_DELIM);

    assert_brk_flag_source_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_flag) |-> $past(brk_hit));

    assert_sync_err_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(synch_err) |-> $past(hdr_state) == HS_SYNC);

    assert_id_flag_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(id_flag) |-> $past(hdr_state) == HS_IDENT);

    assert_id_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(id_value) |-> (id_flag && $past(hdr_state) == HS_IDENT));

    assert_clear_brk_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_status && !brk_hit) |=> !brk_flag);

    assert_parity_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(parity_err) |-> ($past(parity_chk_en) && $past(hdr_state) == HS_IDENT));
endmodule

bind lin_hdr_rx lin_hdr_rx_chk chk_i (
    .clk(clk), .rst(rst), .clr_status(clr_status), .parity_chk_en(parity_chk_en),
    .brk_flag(brk_flag), .id_flag(id_flag), .synch_err(synch_err),
    .parity_err(parity_err), .id_value(id_value), .hdr_state(hdr_state),
    .brk_hit(brk_hit)
);

// File: tb/lin_hdr_rx_tb_top.sv
module lin_hdr_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       parity_chk_en = 1'b0;
    logic       clr_status = 1'b0;
    logic       brk_flag, id_flag, synch_err, parity_err;
    logic [7:0] id_value;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lin_hdr_rx dut_i (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .parity_chk_en(parity_chk_en), .clr_status(clr_status),
        .brk_flag(brk_flag), .id_flag(id_flag), .synch_err(synch_err),
        .parity_err(parity_err), .id_value(id_value)
    );

    function automatic bit par_good(input logic [7:0] id);
        bit p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        bit p1 = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return (id[6] == p0) && (id[7] == p1);
    endfunction

    function automatic logic [7:0] fix_par(input logic [7:0] id);
        logic [7:0] r = id;
        r[6] = id[0] ^ id[1] ^ id[2] ^ id[4];
        r[7] = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input bit b, input bit i,
                             input bit s, input bit p, input logic [7:0] v);
        check({req, " brk_flag"}, {7'd0, brk_flag}, {7'd0, b});
        check({req, " id_flag"}, {7'd0, id_flag}, {7'd0, i});
        check({req, " synch_err"}, {7'd0, synch_err}, {7'd0, s});
        check({req, " parity_err"}, {7'd0, parity_err}, {7'd0, p});
        check({req, " id_value"}, id_value, v);
    endtask

    // one tick: line value set, settle through synchronizer, then strobe
    task automatic one_tick(input logic v);
        rxd = v;
        repeat (3) @(negedge clk);
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
    endtask

    task automatic send_bit(input logic b, input int flip);
        for (int k = 0; k < 16; k++) one_tick((k == flip) ? ~b : b);
    endtask

    task automatic send_char(input logic [7:0] c, input int fbit, input int ftick);
        send_bit(1'b0, (fbit == 0) ? ftick : -1);
        for (int k = 0; k < 8; k++) send_bit(c[k], (fbit == k + 1) ? ftick : -1);
        send_bit(1'b1, (fbit == 9) ? ftick : -1);
        send_bit(1'b1, -1);
    endtask

    task automatic send_break(input int nbits);
        for (int k = 0; k < nbits; k++) send_bit(1'b0, -1);
        send_bit(1'b1, -1);
    endtask

    task automatic clear_pulse();
        @(negedge clk);
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] prev_id;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check_all("R1", 0, 0, 0, 0, 8'h00);

        // R4: characters without break are ignored
        send_char(8'h55, -1, -1);
        send_char(8'h3c, -1, -1);
        check_all("R4", 0, 0, 0, 0, 8'h00);

        // R2: 10 bit times low is no break
        send_break(10);
        send_char(8'h55, -1, -1);
        send_char(8'h12, -1, -1);
        check_all("R2 short", 0, 0, 0, 0, 8'h00);

        // R2/R3/R6: exactly 11 bit times, then full header
        send_break(11);
        check({"R2 exact brk"}, {7'd0, brk_flag}, 8'h01);
        send_char(8'h55, -1, -1);
        send_char(8'h8b, -1, -1);
        check_all("R3 R6 header", 1, 1, 0, 0, 8'h8b);

        // R7: clear keeps identifier
        clear_pulse();
        check_all("R7 clear", 0, 0, 0, 0, 8'h8b);

        // R9: start glitch while hunting synch is dropped
        send_break(12);
        for (int k = 0; k < 6; k++) one_tick(1'b0);
        for (int k = 0; k < 26; k++) one_tick(1'b1);
        send_char(8'h55, -1, -1);
        send_char(8'h21, -1, -1);
        check_all("R9 glitch", 1, 1, 0, 0, 8'h21);
        clear_pulse();

        // R5: bad synch, following char ignored
        send_break(11);
        send_char(8'h54, -1, -1);
        send_char(8'hee, -1, -1);
        check_all("R5 bad synch", 1, 0, 1, 0, 8'h21);
        clear_pulse();

        // R8: parity enabled, bad parity
        parity_chk_en = 1'b1;
        send_break(11);
        send_char(8'h55, -1, -1);
        send_char(fix_par(8'h05) ^ 8'h80, -1, -1);
        check_all("R8 bad parity", 1, 1, 0, 1, fix_par(8'h05) ^ 8'h80);
        clear_pulse();
        parity_chk_en = 1'b0;
        prev_id = id_value;

        // random headers with noise on a mid-bit tick
        for (int it = 0; it < 22; it++) begin
            int         nb   = 11 + ($urandom % 3);
            bit         good = ($urandom % 4) != 0;
            logic [7:0] syn  = 8'h55;
            logic [7:0] id   = 8'($urandom);
            bit         pen  = $urandom % 2;
            int         fb   = $urandom % 10;
            int         ft   = 7 + ($urandom % 3);
            bit         ok;
            if (!good) begin
                syn = 8'($urandom);
                if (syn == 8'h55) syn = 8'h5d;
            end
            if ($urandom % 2) id = fix_par(id);
            ok = par_good(id);
            parity_chk_en = pen;
            clear_pulse();
            send_break(nb);
            send_char(syn, -1, -1);
            send_char(id, fb, ft);
            if (good) begin
                check_all("R9 R6 R8 random", 1, 1, 0, pen & !ok, id);
                prev_id = id;
            end else begin
                check_all("R5 random", 1, 0, 1, 0, prev_id);
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule